// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block takes a vector of external interrupt lines and turns them into interrupt messages, one at a time. Each pin owns a 64-bit redirection entry. The entry holds the vector, the delivery mode, the destination, the destination mode, the trigger mode and a mask. Each pin also owns a request bit. Level-triggered entries also carry a remote-pending flag.

A fixed-priority picker scans the pins from the lowest index upward. It launches the first pending, unmasked, eligible pin into a single output register. That register is offered downstream with a valid/ready handshake.

End-of-interrupt notifications arrive with a vector number. Each one releases the level-triggered entries that are waiting on that vector. The entries are programmed through a plain write port and can be observed through a combinational read port.

With the legacy remap option on, input line 0 is steered to pin 2 and pin 0 receives no input.

Top module: `irq_redirect_engine`

## Requirements
- R1: After reset every entry reads as 0x0000_0000_0001_0000 (mask set, all else zero), no request bit is set, no remote-pending flag is set and `dlv_valid` is low.
- R2: With `LEGACY_REMAP`=1, input line 0 raises pin 2 (it is delivered with pin 2's entry and `dlv_pin`=2), and pin 0 is never delivered. Every other input line k drives pin k.
- R3: On a level entry (bit 15 = 1), the request bit follows the input line. Delivering the pin keeps the request and sets remote-pending (bit 14). The pin is not delivered again while remote-pending is set. Deasserting the input clears the request.
- R4: On an edge entry (bit 15 = 0), a rising input on an unmasked pin is recorded and delivered exactly once. `dlv_valid` rises on the second clock edge after the input rises.
- R5: A rising edge that arrives while the entry's mask (bit 16) is set is discarded. Unmasking the pin afterwards delivers nothing.
- R6: When several pins are pending together, they are delivered in ascending pin order.
- R7: While `dlv_valid` is high and `dlv_ready` is low, the output stays valid and every payload field holds its value.
- R8: An end-of-interrupt with vector V clears remote-pending in each entry that has it set and whose vector (bits 7:0) equals V. A pin so released whose input is still asserted and whose entry is unmasked is delivered again. A non-matching vector changes nothing.
- R9: A table write never changes remote-pending directly; bit 14 of the write data is ignored. A write that makes the entry edge-triggered clears remote-pending. A write that unmasks a pin holding a request leads to its delivery.
- R10: The entry layout is: vector 7:0, delivery mode 10:8, destination mode 11, remote-pending 14, trigger 15, mask 16, destination 63:56. Other bits read as zero. A delivery presents the delivered pin's vector, mode, destination, destination mode and trigger fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_PINS | Interrupt input lines |
| tbl_we | input | 1 | Entry write strobe |
| tbl_widx | input | $clog2(NUM_PINS) | Entry index to write |
| tbl_wdata | input | 64 | Entry write data |
| tbl_ridx | input | $clog2(NUM_PINS) | Entry index to read |
| tbl_rdata | output | 64 | Entry read data (combinational) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | End-of-interrupt vector |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_ready | input | 1 | Downstream accepts the delivery |
| dlv_pin | output | $clog2(NUM_PINS) | Pin being delivered |
| dlv_vector | output | 8 | Delivered vector |
| dlv_mode | output | 3 | Delivery mode |
| dlv_dest | output | 8 | Destination |
| dlv_dest_mode | output | 1 | Destination mode |
| dlv_level | output | 1 | Trigger mode of the delivery (1 = level) |

## Verification
The hardest state to reach from the ports is a level pin whose remote-pending flag is set while its input stays asserted. In that state an end-of-interrupt with a non-matching vector must change nothing, and the matching vector must cause exactly one new delivery.

The bench reaches this state by holding the line high through a whole sequence. It first lets the first delivery complete. It then sends a wrong vector, then the right one. After each step it reads bit 14 back through the read port.

Ordering under back-pressure is reached by pulsing four edge pins in the same cycle while `dlv_ready` is held low.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

   localparam int unsigned RTE_W       = 64;
   localparam int unsigned VEC_LSB     = 0;
   localparam int unsigned MODE_LSB    = 8;
   localparam int unsigned DMODE_BIT   = 11;
   localparam int unsigned RPEND_BIT   = 14;
   localparam int unsigned TRIG_BIT    = 15;
   localparam int unsigned MASK_BIT    = 16;
   localparam int unsigned DEST_LSB    = 56;

   typedef struct packed {
      logic [7:0] dest;
      logic       mask;
      logic       level;
      logic       rpend;
      logic       dmode;
      logic [2:0] mode;
      logic [7:0] vector;
   } rte_t;

   function automatic rte_t rte_unpack(logic [RTE_W-1:0] w);
      rte_t e;
      e.vector = w[VEC_LSB +: 8];
      e.mode   = w[MODE_LSB +: 3];
      e.dmode  = w[DMODE_BIT];
      e.rpend  = w[RPEND_BIT];
      e.level  = w[TRIG_BIT];
      e.mask   = w[MASK_BIT];
      e.dest   = w[DEST_LSB +: 8];
      return e;
   endfunction

   function automatic logic [RTE_W-1:0] rte_pack(rte_t e);
      logic [RTE_W-1:0] w;
      w = '0;
      w[VEC_LSB +: 8]  = e.vector;
      w[MODE_LSB +: 3] = e.mode;
      w[DMODE_BIT]     = e.dmode;
      w[RPEND_BIT]     = e.rpend;
      w[TRIG_BIT]      = e.level;
      w[MASK_BIT]      = e.mask;
      w[DEST_LSB +: 8] = e.dest;
      return w;
   endfunction

endpackage

// File: rtl/irq_in_stage.sv
module irq_in_stage #(
   parameter int unsigned NUM_PINS     = 24,
   parameter bit          LEGACY_REMAP = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] irq_in,
   output logic [NUM_PINS-1:0] line_o,
   output logic [NUM_PINS-1:0] rise_o
);

   logic [NUM_PINS-1:0] prev_q;

   generate
      if (LEGACY_REMAP) begin : g_remap
         always_comb begin
            line_o    = irq_in;
            line_o[0] = 1'b0;
            line_o[2] = irq_in[0] | irq_in[2];
         end
      end else begin : g_direct
         assign line_o = irq_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= line_o;
   end

   assign rise_o = line_o & ~prev_q;

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int unsigned N     = 24,
   parameter int unsigned IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/irq_rte_table.sv
module irq_rte_table
   import irq_redir_pkg::*;
#(
   parameter int unsigned NUM_PINS = 24,
   parameter int unsigned IDX_W    = $clog2(NUM_PINS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [IDX_W-1:0]       widx,
   input  logic [RTE_W-1:0]       wdata,
   input  logic [IDX_W-1:0]       ridx,
   output logic [RTE_W-1:0]       rdata,
   input  logic                   eoi_valid,
   input  logic [7:0]             eoi_vector,
   input  logic                   launch,
   input  logic [IDX_W-1:0]       launch_idx,
   output rte_t [NUM_PINS-1:0]    rte_o
);

   rte_t [NUM_PINS-1:0] tbl_q;
   rte_t [NUM_PINS-1:0] tbl_d;
   rte_t                reset_rte;
   rte_t                wr_rte;
   logic                unused_wbits;

   assign unused_wbits = ^{wdata[DEST_LSB-1:MASK_BIT+1], wdata[RPEND_BIT-1:DMODE_BIT+1]};
   assign wr_rte       = rte_unpack(wdata);

   always_comb begin
      reset_rte      = '0;
      reset_rte.mask = 1'b1;
   end

   always_comb begin
      for (int i = 0; i < NUM_PINS; i++) begin
         tbl_d[i] = tbl_q[i];
         if (we && widx == IDX_W'(i)) begin
            tbl_d[i]       = wr_rte;
            tbl_d[i].rpend = tbl_q[i].rpend;
         end
         if (eoi_valid && tbl_q[i].rpend && tbl_q[i].vector == eoi_vector)
            tbl_d[i].rpend = 1'b0;
         if (launch && launch_idx == IDX_W'(i) && tbl_q[i].level)
            tbl_d[i].rpend = 1'b1;
         if (!tbl_d[i].level)
            tbl_d[i].rpend = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PINS; i++) tbl_q[i] <= reset_rte;
      end else begin
         tbl_q <= tbl_d;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_PINS; i++)
         if (ridx == IDX_W'(i)) rdata = rte_pack(tbl_q[i]);
   end

   assign rte_o = tbl_q;

   generate
      for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
         // R3: a level pin that is launched is marked remote-pending
         a_r3_level_marks: assert property (@(posedge clk) disable iff (!rst_n)
            (launch && launch_idx == IDX_W'(g) && tbl_q[g].level && !(we && widx == IDX_W'(g)))
            |=> tbl_q[g].rpend);
         // R8: a matching end-of-interrupt releases the entry
         a_r8_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_valid && tbl_q[g].rpend && tbl_q[g].vector == eoi_vector &&
             !(launch && launch_idx == IDX_W'(g)) && !(we && widx == IDX_W'(g)))
            |=> !tbl_q[g].rpend);
      end
   endgenerate

endmodule

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine
   import irq_redir_pkg::*;
#(
   parameter int unsigned NUM_PINS     = 24,
   parameter bit          LEGACY_REMAP = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PINS-1:0]         irq_in,
   input  logic                        tbl_we,
   input  logic [$clog2(NUM_PINS)-1:0] tbl_widx,
   input  logic [63:0]                 tbl_wdata,
   input  logic [$clog2(NUM_PINS)-1:0] tbl_ridx,
   output logic [63:0]                 tbl_rdata,
   input  logic                        eoi_valid,
   input  logic [7:0]                  eoi_vector,
   output logic                        dlv_valid,
   input  logic                        dlv_ready,
   output logic [$clog2(NUM_PINS)-1:0] dlv_pin,
   output logic [7:0]                  dlv_vector,
   output logic [2:0]                  dlv_mode,
   output logic [7:0]                  dlv_dest,
   output logic                        dlv_dest_mode,
   output logic                        dlv_level
);

   localparam int unsigned IDX_W = $clog2(NUM_PINS);

   generate
      if (NUM_PINS < 3 || NUM_PINS > 256) begin : g_bad_pins
         $error("irq_redirect_engine: NUM_PINS must lie in 3..256");
      end
   endgenerate

   logic [NUM_PINS-1:0] line;
   logic [NUM_PINS-1:0] rise;
   logic [NUM_PINS-1:0] req_q;
   logic [NUM_PINS-1:0] req_d;
   logic [NUM_PINS-1:0] elig;
   rte_t [NUM_PINS-1:0] rte;
   logic                found;
   logic [IDX_W-1:0]    pick_idx;
   logic                out_free;
   logic                launch;
   rte_t                out_q;

   irq_in_stage #(.NUM_PINS(NUM_PINS), .LEGACY_REMAP(LEGACY_REMAP)) u_in (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .line_o(line), .rise_o(rise));

   irq_rte_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .we(tbl_we), .widx(tbl_widx), .wdata(tbl_wdata),
      .ridx(tbl_ridx), .rdata(tbl_rdata),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .launch(launch), .launch_idx(pick_idx), .rte_o(rte));

   irq_lowest_pick #(.N(NUM_PINS), .IDX_W(IDX_W)) u_pick (
      .req_i(elig), .found_o(found), .idx_o(pick_idx));

   assign out_free = !dlv_valid || dlv_ready;
   assign launch   = found && out_free;

   always_comb begin
      for (int i = 0; i < NUM_PINS; i++) begin
         if (rte[i].level)
            req_d[i] = line[i];
         else
            req_d[i] = (req_q[i] & ~(launch && pick_idx == IDX_W'(i))) |
                       (rise[i] & ~rte[i].mask);
         elig[i] = req_q[i] & ~rte[i].mask & ~(rte[i].level & rte[i].rpend);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dlv_valid <= 1'b0;
         dlv_pin   <= '0;
         out_q     <= '0;
      end else if (out_free) begin
         dlv_valid <= found;
         if (found) begin
            dlv_pin <= pick_idx;
            out_q   <= rte[pick_idx];
         end
      end
   end

   assign dlv_vector    = out_q.vector;
   assign dlv_mode      = out_q.mode;
   assign dlv_dest      = out_q.dest;
   assign dlv_dest_mode = out_q.dmode;
   assign dlv_level     = out_q.level;

   // R7: back-pressure holds the offered delivery unchanged
   a_r7_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_pin) &&
      $stable(dlv_vector) && $stable(dlv_dest) && $stable(dlv_mode)));

   generate
      if (LEGACY_REMAP) begin : g_remap_chk
         // R2: pin 0 receives no input when remapped
         a_r2_no_pin_zero: assert property (@(posedge clk) disable iff (!rst_n)
            dlv_valid |-> dlv_pin != '0);
      end
      for (genvar g = 0; g < NUM_PINS; g++) begin : g_edge_chk
         // R4: an edge request is consumed when launched
         a_r4_edge_consumed: assert property (@(posedge clk) disable iff (!rst_n)
            (launch && pick_idx == IDX_W'(g) && !rte[g].level && !rise[g] &&
             !(tbl_we && tbl_widx == IDX_W'(g)))
            |=> !req_q[g]);
      end
   endgenerate

endmodule

// File: tb/irq_redirect_engine_bench.sv
`timescale 1ns/100ps
module irq_redirect_engine_bench;

   localparam int NP = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] irq_in = '0;
   logic          tbl_we = 1'b0;
   logic [IW-1:0] tbl_widx = '0;
   logic [63:0]   tbl_wdata = '0;
   logic [IW-1:0] tbl_ridx = '0;
   logic [63:0]   tbl_rdata;
   logic          eoi_valid = 1'b0;
   logic [7:0]    eoi_vector = '0;
   logic          dlv_valid;
   logic          dlv_ready = 1'b1;
   logic [IW-1:0] dlv_pin;
   logic [7:0]    dlv_vector;
   logic [2:0]    dlv_mode;
   logic [7:0]    dlv_dest;
   logic          dlv_dest_mode;
   logic          dlv_level;

   irq_redirect_engine #(.NUM_PINS(NP), .LEGACY_REMAP(1'b1)) u_irq_redirect_engine (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .tbl_we(tbl_we), .tbl_widx(tbl_widx), .tbl_wdata(tbl_wdata),
      .tbl_ridx(tbl_ridx), .tbl_rdata(tbl_rdata),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
      .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_pin(dlv_pin),
      .dlv_vector(dlv_vector), .dlv_mode(dlv_mode), .dlv_dest(dlv_dest),
      .dlv_dest_mode(dlv_dest_mode), .dlv_level(dlv_level));

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int        cap_n = 0;
   int        cap_pin [256];
   int        cap_vec [256];
   int        cap_dest[256];
   int        cap_mode[256];
   int        cap_dm  [256];
   int        cap_lvl [256];

   always @(negedge clk) begin
      #2;
      if (rst_n && dlv_valid && dlv_ready && cap_n < 256) begin
         cap_pin[cap_n]  = dlv_pin;
         cap_vec[cap_n]  = dlv_vector;
         cap_dest[cap_n] = dlv_dest;
         cap_mode[cap_n] = dlv_mode;
         cap_dm[cap_n]   = dlv_dest_mode;
         cap_lvl[cap_n]  = dlv_level;
         cap_n++;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(int vec, int mode, int dm, int lvl, int msk, int dest);
      logic [63:0] w = '0;
      w[7:0]   = vec[7:0];
      w[10:8]  = mode[2:0];
      w[11]    = dm[0];
      w[15]    = lvl[0];
      w[16]    = msk[0];
      w[63:56] = dest[7:0];
      return w;
   endfunction

   function automatic logic [63:0] sweep_rte(int p, int msk);
      return mk(32'h20 + p, p % 8, p % 2, 0, msk, 32'h10 + p);
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int idx, input logic [63:0] d);
      @(negedge clk);
      tbl_we = 1'b1; tbl_widx = IW'(idx); tbl_wdata = d;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [63:0] d);
      tbl_ridx = IW'(idx);
      #1;
      d = tbl_rdata;
   endtask

   task automatic pulse(input int k);
      @(negedge clk);
      irq_in[k] = 1'b1;
      @(negedge clk);
      irq_in[k] = 1'b0;
   endtask

   task automatic eoi(input int v);
      @(negedge clk);
      eoi_valid = 1'b1; eoi_vector = v[7:0];
      @(negedge clk);
      eoi_valid = 1'b0;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      int base;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1: reset state
      for (int p = 0; p < NP; p++) begin
         rd(p, d);
         check(d == 64'h1_0000, "R1", "reset entry", d, 64'h1_0000);
      end
      check(dlv_valid == 1'b0, "R1", "valid after reset", dlv_valid, 0);

      // R4 / R10 / R2: edge sweep over every input line
      for (int p = 1; p < NP; p++) wr(p, sweep_rte(p, 0));
      tick(2);
      check(cap_n == 0, "R1", "no delivery from reset entries", cap_n, 0);
      for (int k = 0; k < NP; k++) begin
         int ep;
         ep = (k == 0) ? 2 : k;
         base = cap_n;
         pulse(k);
         if (k == 1) begin
            check(dlv_valid == 1'b0, "R4", "valid one edge after rise", dlv_valid, 0);
            @(posedge clk); #1;
            check(dlv_valid == 1'b1, "R4", "valid two edges after rise", dlv_valid, 1);
         end
         tick(5);
         check(cap_n - base == 1, "R4", "one delivery per edge", cap_n - base, 1);
         check(cap_pin[base] == ep, (k == 0) ? "R2" : "R10", "delivered pin", cap_pin[base], ep);
         check(cap_vec[base] == 32'h20 + ep, "R10", "vector", cap_vec[base], 32'h20 + ep);
         check(cap_dest[base] == 32'h10 + ep, "R10", "destination", cap_dest[base], 32'h10 + ep);
         check(cap_mode[base] == ep % 8, "R10", "delivery mode", cap_mode[base], ep % 8);
         check(cap_dm[base] == ep % 2, "R10", "destination mode", cap_dm[base], ep % 2);
         check(cap_lvl[base] == 0, "R10", "trigger field", cap_lvl[base], 0);
      end

      // R5: masked edges are lost
      for (int p = 1; p < NP; p++) begin
         base = cap_n;
         wr(p, sweep_rte(p, 1));
         pulse(p);
         tick(2);
         wr(p, sweep_rte(p, 0));
         tick(4);
         check(cap_n == base, "R5", "masked edge discarded", cap_n - base, 0);
      end

      // R3 / R8: level pin with remote-pending
      wr(3, mk(32'h41, 1, 0, 1, 0, 32'h33));
      base = cap_n;
      @(negedge clk); irq_in[3] = 1'b1;
      tick(6);
      check(cap_n - base == 1, "R3", "single level delivery", cap_n - base, 1);
      check(cap_pin[base] == 3 && cap_lvl[base] == 1, "R3", "level pin/trigger",
            cap_pin[base] * 16 + cap_lvl[base], 3 * 16 + 1);
      check(cap_vec[base] == 32'h41, "R10", "level vector", cap_vec[base], 32'h41);
      rd(3, d);
      check(d[14] == 1'b1, "R3", "remote-pending set", d[14], 1);
      eoi(32'h40);
      tick(4);
      check(cap_n - base == 1, "R8", "wrong vector ignored", cap_n - base, 1);
      rd(3, d);
      check(d[14] == 1'b1, "R8", "remote-pending kept on wrong vector", d[14], 1);
      eoi(32'h41);
      tick(4);
      check(cap_n - base == 2, "R8", "redelivery after matching EOI", cap_n - base, 2);
      rd(3, d);
      check(d[14] == 1'b1, "R8", "remote-pending set again", d[14], 1);

      // R9: switching to edge clears remote-pending
      wr(3, mk(32'h41, 1, 0, 0, 1, 32'h33));
      rd(3, d);
      check(d[14] == 1'b0, "R9", "edge write clears remote-pending", d[14], 0);
      @(negedge clk); irq_in[3] = 1'b0;
      tick(2);

      // R3: deasserted level input clears the request
      wr(3, mk(32'h41, 1, 0, 1, 0, 32'h33));
      base = cap_n;
      @(negedge clk); irq_in[3] = 1'b1;
      tick(5);
      @(negedge clk); irq_in[3] = 1'b0;
      tick(2);
      eoi(32'h41);
      tick(6);
      check(cap_n - base == 1, "R3", "no redelivery after input dropped", cap_n - base, 1);
      rd(3, d);
      check(d[14] == 1'b0, "R8", "remote-pending released", d[14], 0);

      // R9: masked level request delivered once unmasked
      wr(5, mk(32'h55, 2, 1, 1, 1, 32'h05));
      base = cap_n;
      @(negedge clk); irq_in[5] = 1'b1;
      tick(5);
      check(cap_n == base, "R9", "masked level not delivered", cap_n - base, 0);
      wr(5, mk(32'h55, 2, 1, 1, 0, 32'h05));
      tick(5);
      check(cap_n - base == 1 && cap_pin[base] == 5, "R9", "unmasking write delivers",
            cap_n - base, 1);
      @(negedge clk); irq_in[5] = 1'b0;
      wr(5, mk(32'h55, 2, 1, 0, 1, 32'h05));

      // R9: bit 14 of write data is ignored
      wr(1, sweep_rte(1, 1) | 64'h4000 | 64'h8000);
      rd(1, d);
      check(d[14] == 1'b0, "R9", "remote-pending not writable", d[14], 0);
      wr(1, sweep_rte(1, 0));
      wr(3, sweep_rte(3, 0));
      tick(3);

      // R6 / R7: ascending order under back-pressure
      base = cap_n;
      @(negedge clk); dlv_ready = 1'b0;
      @(negedge clk); irq_in[6] = 1'b1; irq_in[1] = 1'b1; irq_in[4] = 1'b1; irq_in[3] = 1'b1;
      @(negedge clk); irq_in = '0;
      tick(2);
      for (int c = 0; c < 5; c++) begin
         #1;
         check(dlv_valid == 1'b1 && dlv_pin == 1 && dlv_vector == 8'h21, "R7",
               "held payload under stall", {dlv_valid, dlv_pin}, {1'b1, 3'd1});
         @(negedge clk);
      end
      dlv_ready = 1'b1;
      tick(8);
      check(cap_n - base == 4, "R6", "four deliveries", cap_n - base, 4);
      check(cap_pin[base] == 1, "R6", "first", cap_pin[base], 1);
      check(cap_pin[base + 1] == 3, "R6", "second", cap_pin[base + 1], 3);
      check(cap_pin[base + 2] == 4, "R6", "third", cap_pin[base + 2], 4);
      check(cap_pin[base + 3] == 6, "R6", "fourth", cap_pin[base + 3], 6);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule